// File: doc/BRIEF.md
# Peripheral Task, Event and Interrupt Hub

This block sits between a register bus and the functional core of a peripheral, and carries the generic signalling logic. Firmware starts actions by writing 1 to a task address. The core asks for the same actions with its own strobe inputs. Every accepted trigger leaves the block as a one-clock pulse on `task_o`.

When the core strobes an event, a sticky flag is set. Firmware can read the flag and can clear it only by writing 0 to it. Fixed shortcut links, each gated by one enable bit, turn an event strobe into a pulse on a linked task without any firmware involvement. The flags that have their interrupt-enable bit set are ORed into one interrupt line.

Register map, as word addresses on `bus_addr`:
- 0x00 + t: task t.
- 0x20 + e: event flag e, in bit 0.
- 0x40: shortcut enables, bit k for shortcut k.
- 0x41: interrupt-enable register.
- 0x42: interrupt-enable set.
- 0x43: interrupt-enable clear.
- 0x44: block enable, in bit 0.

Reads are combinational from `bus_addr`. Unmapped addresses read 0. With the default parameters there are four tasks, four events and two shortcuts. Shortcut 0 links event 0 to task 1. Shortcut 1 links event 2 to task 0.

Top module: `tev_hub`

## Requirements
- R1: While the block enable is 1, a write to address 0x00+t with `bus_wdata[0]`=1 makes `task_o[t]` high for exactly the one cycle that follows the write.
- R2: While enabled, `core_task_i[t]` high in a cycle makes `task_o[t]` high in the next cycle, for one cycle per strobe cycle.
- R3: A write with `bus_wdata[0]`=0 to a task address produces no pulse, and task addresses always read 0.
- R4: While enabled, `core_evt_i[e]` high in a cycle sets flag e from the next cycle on, and address 0x20+e then reads 1.
- R5: A flag is cleared only by a write to its address with `bus_wdata[0]`=0. Writing 1 leaves it unchanged.
- R6: If an event strobe and a clearing write hit the same flag in the same cycle, the flag stays 1.
- R7: While enabled, a strobe on the source event of shortcut k whose enable bit (address 0x40, bit k) is 1 pulses the linked task one cycle later. This also happens when the flag is already 1. With the enable bit at 0 there is no pulse.
- R8: `irq_o` is high exactly when some event has its flag at 1 and its interrupt-enable bit (bit e) at 1. It rises in the cycle after the flag is set.
- R9: A write to 0x41 loads the interrupt enables. Writing 1 bits to 0x42 sets them and writing 1 bits to 0x43 clears them. Zero bits in a set or clear write have no effect. All three addresses read back the current enables.
- R10: Once high, `irq_o` stays high until firmware clears the causing flag or its enable bit.
- R11: While the block enable (address 0x44, bit 0) is 0, firmware task writes, core task strobes and event strobes have no effect: no pulses and no flag is set.
- R12: After reset, no task pulses, all flags are 0, all enables are 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| core_task_i | input | NT | Task strobes from the peripheral core |
| core_evt_i | input | NE | Event strobes from the peripheral core |
| task_o | output | NT | One-cycle task pulses to the core |
| irq_o | output | 1 | Combined interrupt |

## Verification
Task pulses from firmware writes, core strobes and shortcuts all appear on `task_o` in the cycle after the stimulus cycle. The driver stamps each expected pulse with that cycle number, and the monitor compares it in that cycle and flags any pulse that has no stamp. Flags and `irq_o` change on the edge that captures the stimulus. The bench therefore reads or samples them at least one falling edge after that stimulus, and samples `bus_rdata` within the same cycle that sets the address.

// File: rtl/tev_pkg.sv
// Package: address map and bus write type shared by the hub and its units.
package tev_pkg;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int MAX_LINES   = 32;
    localparam int TASK_BASE   = 'h00;
    localparam int EVT_BASE    = 'h20;
    localparam int REG_SHORT   = 'h40;
    localparam int REG_IEN     = 'h41;
    localparam int REG_IEN_SET = 'h42;
    localparam int REG_IEN_CLR = 'h43;
    localparam int REG_ENABLE  = 'h44;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;
endpackage

// File: rtl/tev_task_unit.sv
// Task pulse unit: merges firmware, core and shortcut requests into a
// registered one-cycle pulse per task. Assumes requests are per-cycle strobes.
module tev_task_unit #(
    parameter int NT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [NT-1:0] fw_req,
    input  logic [NT-1:0] hw_req,
    input  logic [NT-1:0] sc_req,
    output logic [NT-1:0] pulse
);
    // Register the merged request; nothing passes while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= '0;
        else        pulse <= en ? (fw_req | hw_req | sc_req) : '0;
    end
endmodule

// File: rtl/tev_event_unit.sv
// Event flag unit: sticky flags set by core strobes, cleared by firmware
// writes of 0. A strobe in the same cycle as a clear wins.
module tev_event_unit #(
    parameter int NE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [NE-1:0] strobe,
    input  logic [NE-1:0] clr_hit,
    output logic [NE-1:0] flags
);
    // Clear first, then OR in accepted strobes so that set dominates.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_hit) | (en ? strobe : '0);
    end
endmodule

// File: rtl/tev_irq_unit.sv
// Interrupt unit: holds the enable mask with load, set and clear writes and
// combines enabled flags into one level line. Assumes one write per cycle.
module tev_irq_unit #(
    parameter int NE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_load,
    input  logic          wr_set,
    input  logic          wr_clr,
    input  logic [NE-1:0] wdata,
    input  logic [NE-1:0] flags,
    output logic [NE-1:0] mask,
    output logic          irq
);
    // Update the enable mask according to which alias was written.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (wr_load) mask <= wdata;
        else if (wr_set)  mask <= mask | wdata;
        else if (wr_clr)  mask <= mask & ~wdata;
    end

    // Level interrupt from registered state only.
    assign irq = |(flags & mask);
endmodule

// File: rtl/tev_short_route.sv
// Shortcut router: fixed event-to-task links, each gated by an enable bit.
// Assumes every link's source is below NE and destination below NT.
module tev_short_route #(
    parameter int                NE     = 4,
    parameter int                NT     = 4,
    parameter int                NS     = 2,
    parameter logic [NS*8-1:0]   SC_SRC = '0,
    parameter logic [NS*8-1:0]   SC_DST = '0
) (
    input  logic [NE-1:0] evt_strobe,
    input  logic [NS-1:0] short_en,
    output logic [NT-1:0] req
);
    logic [NT-1:0] sel [NS];

    for (genvar k = 0; k < NS; k++) begin : g_link
        localparam int SRC = int'(SC_SRC[k*8 +: 8]);
        localparam int DST = int'(SC_DST[k*8 +: 8]);
        assign sel[k] = {NT{short_en[k] & evt_strobe[SRC]}} & NT'(1 << DST);
    end

    // OR all link contributions into the task request vector.
    always_comb begin
        req = '0;
        for (int k = 0; k < NS; k++) req = req | sel[k];
    end
endmodule

// File: rtl/tev_hub.sv
// Task/event/interrupt hub: decodes register writes, holds the block and
// shortcut enables, and ties the task, event, shortcut and interrupt units
// together. Reads are combinational from bus_addr.
module tev_hub
    import tev_pkg::*;
#(
    parameter int              NT     = 4,
    parameter int              NE     = 4,
    parameter int              NS     = 2,
    parameter logic [NS*8-1:0] SC_SRC = 16'h0200,
    parameter logic [NS*8-1:0] SC_DST = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NT-1:0]     core_task_i,
    input  logic [NE-1:0]     core_evt_i,
    output logic [NT-1:0]     task_o,
    output logic              irq_o
);
    bus_wr_t       bw;
    logic          en_q;
    logic [NS-1:0] short_q;
    logic [NT-1:0] fw_task_hit;
    logic [NE-1:0] evt_clr_hit;
    logic [NE-1:0] evt_flags;
    logic [NE-1:0] ien_mask;
    logic [NT-1:0] sc_req;
    logic          wr_short, wr_ien, wr_set, wr_clr, wr_en;
    logic          unused_wdata;

    assign bw           = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};
    assign unused_wdata = ^bus_wdata;

    // Per-line decode of task triggers and flag clears.
    for (genvar t = 0; t < NT; t++) begin : g_task_dec
        assign fw_task_hit[t] = bw.wr && bw.addr == ADDR_W'(TASK_BASE + t) && bw.data[0];
    end
    for (genvar e = 0; e < NE; e++) begin : g_evt_dec
        assign evt_clr_hit[e] = bw.wr && bw.addr == ADDR_W'(EVT_BASE + e) && !bw.data[0];
    end

    assign wr_short = bw.wr && bw.addr == ADDR_W'(REG_SHORT);
    assign wr_ien   = bw.wr && bw.addr == ADDR_W'(REG_IEN);
    assign wr_set   = bw.wr && bw.addr == ADDR_W'(REG_IEN_SET);
    assign wr_clr   = bw.wr && bw.addr == ADDR_W'(REG_IEN_CLR);
    assign wr_en    = bw.wr && bw.addr == ADDR_W'(REG_ENABLE);

    // Block enable and shortcut enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            short_q <= '0;
        end else begin
            if (wr_en)    en_q    <= bw.data[0];
            if (wr_short) short_q <= bw.data[NS-1:0];
        end
    end

    tev_short_route #(
        .NE(NE), .NT(NT), .NS(NS), .SC_SRC(SC_SRC), .SC_DST(SC_DST)
    ) u_route (
        .evt_strobe(core_evt_i),
        .short_en  (short_q),
        .req       (sc_req)
    );

    tev_task_unit #(.NT(NT)) u_task (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q),
        .fw_req(fw_task_hit),
        .hw_req(core_task_i),
        .sc_req(sc_req),
        .pulse (task_o)
    );

    tev_event_unit #(.NE(NE)) u_event (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_q),
        .strobe (core_evt_i),
        .clr_hit(evt_clr_hit),
        .flags  (evt_flags)
    );

    tev_irq_unit #(.NE(NE)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_load(wr_ien),
        .wr_set (wr_set),
        .wr_clr (wr_clr),
        .wdata  (bw.data[NE-1:0]),
        .flags  (evt_flags),
        .mask   (ien_mask),
        .irq    (irq_o)
    );

    // Read multiplexer; task addresses and unmapped space read zero.
    always_comb begin
        bus_rdata = '0;
        for (int e = 0; e < NE; e++) begin
            if (bus_addr == ADDR_W'(EVT_BASE + e)) bus_rdata = DATA_W'(evt_flags[e]);
        end
        if (bus_addr == ADDR_W'(REG_SHORT)) bus_rdata = DATA_W'(short_q);
        if (bus_addr == ADDR_W'(REG_IEN) || bus_addr == ADDR_W'(REG_IEN_SET) ||
            bus_addr == ADDR_W'(REG_IEN_CLR)) bus_rdata = DATA_W'(ien_mask);
        if (bus_addr == ADDR_W'(REG_ENABLE)) bus_rdata = DATA_W'(en_q);
    end
endmodule

// File: rtl/tev_hub_chk.sv
// Checker for tev_hub: temporal properties on ports, enable and flag state.
module tev_hub_chk #(
    parameter int NT = 4,
    parameter int NE = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [NT-1:0] core_task_i,
    input logic [NE-1:0] core_evt_i,
    input logic [NT-1:0] task_o,
    input logic          irq_o,
    input logic          en,
    input logic [NE-1:0] flags
);
    // R1, R2, R7: any pulse needs a write or strobe in the cycle before.
    assert_task_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|task_o) |-> $past(bus_wr || (|core_task_i) || (|core_evt_i)));

    // R11: no pulse follows a disabled cycle.
    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> task_o == '0);

    // R11: flags hold while disabled and no write arrives.
    assert_evt_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !bus_wr) |=> flags == $past(flags));

    // R5: without a write no flag can fall.
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (flags & $past(flags)) == $past(flags));

    // R4, R6: an accepted strobe always leaves its flag at 1.
    assert_strobe_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (|core_evt_i)) |=> (flags & $past(core_evt_i)) == $past(core_evt_i));

    // R8: the interrupt rises only after a strobe or a write.
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(bus_wr || (|core_evt_i)));

    // R10: the interrupt holds until firmware writes something.
    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !bus_wr) |=> irq_o);
endmodule

bind tev_hub tev_hub_chk #(.NT(NT), .NE(NE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .core_task_i(core_task_i),
    .core_evt_i (core_evt_i),
    .task_o     (task_o),
    .irq_o      (irq_o),
    .en         (en_q),
    .flags      (evt_flags)
);

// File: tb/tev_hub_test.sv
`timescale 1ns/1ps
module tev_hub_test;
    localparam int NT = 4;
    localparam int NE = 4;
    localparam logic [7:0] T0 = 8'h00, E0 = 8'h20, SHORT = 8'h40, IEN = 8'h41,
                           ISET = 8'h42, ICLR = 8'h43, ENA = 8'h44;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NT-1:0] core_task_i = '0;
    logic [NE-1:0] core_evt_i = '0;
    logic [NT-1:0] task_o;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int            q_cyc [$];
    logic [NT-1:0] q_val [$];
    string         q_tag [$];

    tev_hub uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_task_i(core_task_i),
        .core_evt_i(core_evt_i), .task_o(task_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Driver: apply one cycle of stimulus and stamp the expected pulse.
    task automatic drive(input logic wr, input logic [7:0] a, input logic [31:0] d,
                         input logic [NT-1:0] ct, input logic [NE-1:0] ce,
                         input logic [NT-1:0] exp, input string tag);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; core_task_i = ct; core_evt_i = ce;
        if (exp != '0) begin
            q_cyc.push_back(cyc + 1); q_val.push_back(exp); q_tag.push_back(tag);
        end
    endtask

    task automatic idle();
        drive(1'b0, 8'h00, 32'h0, '0, '0, '0, "");
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        drive(1'b1, a, d, '0, '0, '0, "");
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a; core_task_i = '0; core_evt_i = '0;
        #1 chk(bus_rdata, exp, tag);
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        #1 chk({31'b0, irq_o}, {31'b0, exp}, tag);
    endtask

    // Monitor: pop the item due this cycle; any other pulse is spurious.
    always @(negedge clk) begin
        if (rst_n) begin
            if (q_cyc.size() != 0 && q_cyc[0] == cyc) begin
                chk({28'b0, task_o}, {28'b0, q_val[0]}, q_tag[0]);
                void'(q_cyc.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
            end else if (task_o != '0) begin
                chk({28'b0, task_o}, 32'h0, "unexpected pulse R3/R7/R11");
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        rd_chk(ENA, 0, "R12 enable");
        rd_chk(E0 + 1, 0, "R12 flag");
        rd_chk(SHORT, 0, "R12 shortcuts");
        rd_chk(IEN, 0, "R12 irq mask");
        irq_chk(1'b0, "R12 irq");
        chk({28'b0, task_o}, 0, "R12 tasks");
        // R11: disabled block ignores everything
        drive(1'b1, T0 + 2, 1, '0, '0, '0, "");
        drive(1'b0, 0, 0, 4'b0001, '0, '0, "");
        drive(1'b0, 0, 0, '0, 4'b0001, '0, "");
        idle();
        rd_chk(E0, 0, "R11 flag stays 0 while disabled");
        wr(ENA, 1);
        rd_chk(ENA, 1, "R11 enable readback");
        // R1: firmware task write
        drive(1'b1, T0 + 2, 1, '0, '0, 4'b0100, "R1 fw task pulse");
        idle();
        // R3: write 0 to task, read 0
        drive(1'b1, T0 + 3, 0, '0, '0, '0, "");
        rd_chk(T0 + 3, 0, "R3 task reads 0");
        // R2: core task strobes
        drive(1'b0, 0, 0, 4'b1010, '0, 4'b1010, "R2 core task pulse");
        idle();
        // R4: event sets flag
        drive(1'b0, 0, 0, '0, 4'b0010, '0, "");
        idle();
        rd_chk(E0 + 1, 1, "R4 flag set");
        rd_chk(E0, 0, "R4 other flag clear");
        // R5: write 1 keeps, write 0 clears
        wr(E0 + 1, 1);
        rd_chk(E0 + 1, 1, "R5 write 1 no effect");
        wr(E0 + 1, 0);
        rd_chk(E0 + 1, 0, "R5 write 0 clears");
        // R6: strobe beats clear
        drive(1'b0, 0, 0, '0, 4'b1000, '0, "");
        drive(1'b1, E0 + 3, 0, '0, 4'b1000, '0, "");
        rd_chk(E0 + 3, 1, "R6 strobe wins");
        wr(E0 + 3, 0);
        rd_chk(E0 + 3, 0, "R5 clear after R6");
        // R9: mask load, set, clear aliases
        wr(IEN, 32'h5);
        rd_chk(IEN, 5, "R9 load");
        rd_chk(ISET, 5, "R9 set alias read");
        rd_chk(ICLR, 5, "R9 clr alias read");
        wr(ISET, 32'h8);
        rd_chk(IEN, 32'hD, "R9 set");
        wr(ICLR, 32'h1);
        rd_chk(IEN, 32'hC, "R9 clear");
        wr(ISET, 0);
        wr(ICLR, 0);
        rd_chk(IEN, 32'hC, "R9 zero bits no effect");
        // R8/R10: interrupt
        irq_chk(1'b0, "R8 irq low");
        drive(1'b0, 0, 0, '0, 4'b0100, '0, "");
        idle();
        irq_chk(1'b1, "R8 irq rises");
        repeat (3) idle();
        irq_chk(1'b1, "R10 irq held");
        wr(E0 + 2, 0);
        idle();
        irq_chk(1'b0, "R10 irq drops on clear");
        drive(1'b0, 0, 0, '0, 4'b0001, '0, "");
        idle();
        irq_chk(1'b0, "R8 masked event");
        wr(E0, 0);
        // R7: shortcuts
        wr(SHORT, 1);
        drive(1'b0, 0, 0, '0, 4'b0001, 4'b0010, "R7 shortcut pulse");
        idle();
        drive(1'b0, 0, 0, '0, 4'b0001, 4'b0010, "R7 shortcut with flag set");
        drive(1'b0, 0, 0, '0, 4'b0100, '0, "");
        idle();
        wr(SHORT, 3);
        rd_chk(SHORT, 3, "R7 shortcut readback");
        drive(1'b0, 0, 0, '0, 4'b0100, 4'b0001, "R7 second shortcut");
        drive(1'b1, T0 + 3, 1, 4'b0000, 4'b0101, 4'b1011, "R7 merged pulses");
        idle();
        // R11: disable again
        wr(ENA, 0);
        drive(1'b0, 0, 0, 4'b0001, 4'b0001, '0, "");
        drive(1'b1, T0 + 1, 1, '0, '0, '0, "");
        repeat (3) idle();
        chk(q_cyc.size(), 0, "R1 all expected pulses seen");
        summary();
        $finish;
    end
endmodule